// File: doc/BRIEF.md
# Colour Attribute Mode Controller

This block sits between the CPU I/O bus and the pixel path of a character-based display. The CPU programs colour behaviour through one I/O-mapped control port. That port holds a colour enable, a mode select and a 4-bit IGRB border colour. A read of the same port reports whether colour support is switched on. While characters are drawn, the block forms the RAM address of the attribute byte for the current cell. Once the attribute byte comes back from RAM, the block picks the paper or the pen colour, according to the current pixel bit.

Two addressing schemes are offered:
- **Mode 0 (look-up table):** attributes come from a table indexed by character code and line. The table holds 128 characters of 8 lines each: 64 normal and 64 inverted.
- **Mode 1 (display-file copy):** attributes come from a copy of the display file, placed at the cell address with the top two address bits forced high.

A hardware configuration switch can disable colour entirely. While it is off, the block returns to a fixed fallback of colour off, mode 0 and a bright white border. The block has no video timing and no storage of its own.

Top module: `colour_attr_ctrl`

## Requirements
- R1: While `cfg_colour_en` is 1, a write strobe at address 0x7FEF loads data bit 5 as colour enable, bit 4 as mode (0 = look-up table, 1 = display-file copy) and bits 3:0 as border IGRB. The new values appear at the ports after the clock edge that samples the write.
- R2: A write strobe at any other address leaves colour enable, mode and border unchanged.
- R3: While `cfg_colour_en` is 0, the block behaves as colour off and mode 0, and `border_colour` reads 4'b1111, all from the same cycle. Writes are ignored, and the fallback state is kept after the switch returns to 1 until a new write arrives.
- R4: When `io_rd` is 1 and the address is 0x7FEF, `io_rd_hit` is 1 and `io_rdata` has bit 6 = NOT `cfg_colour_en`, with every other bit 1. At any other address, `io_rd_hit` is 0 and `io_rdata` is 8'hFF.
- R5: In mode 0, `attr_addr` = 0xC000 + index*8 + `char_line`, where the 7-bit index is {`char_code[7]`, `char_code[5:0]`}. `char_code[6]` has no effect.
- R6: In mode 1, `attr_addr` = `dfile_addr` OR 0xC000.
- R7: `attr_ok` is 1 only when colour is enabled and either mode 0 is selected or `dfile_addr` is at least 0x2000.
- R8: With colour enabled, `pix_colour` is `attr_data[3:0]` (pen) when `pixel_bit` is 1, and `attr_data[7:4]` (paper) when it is 0.
- R9: With colour disabled, `pix_colour` is 4'b0000 for a set pixel and 4'b1111 for a clear pixel, whatever `attr_data` holds.
- R10: After reset, colour enable is 0, mode is 0 and the border is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | CPU I/O address |
| io_wdata | input | 8 | CPU I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe |
| cfg_colour_en | input | 1 | Configuration switch, 1 = colour allowed |
| char_code | input | 8 | Current character code |
| char_line | input | 3 | Line within the character cell |
| dfile_addr | input | 16 | Display-file address of the current cell |
| pixel_bit | input | 1 | Current pixel, 1 = set |
| attr_data | input | 8 | Attribute byte read from RAM, {paper IGRB, pen IGRB} |
| attr_addr | output | 16 | Attribute fetch address |
| attr_ok | output | 1 | Attribute address usable |
| pix_colour | output | 4 | IGRB colour of the current pixel |
| border_colour | output | 4 | IGRB border colour |
| io_rd_hit | output | 1 | Status read decoded |
| io_rdata | output | 8 | Status read data |

## Verification
The only state is the control register. If it holds a wrong value, the error shows in the same cycle as a changed `border_colour`. A wrong mode bit shows at once as `attr_addr` jumping between the table region and the display-file copy. A wrong enable bit flips pixels between attribute colours and monochrome. The checks therefore sample one clock after each write, and again right after each switch change, so that a missed force or a late load shows up within one cycle.

// File: rtl/colour_attr_pkg.sv
package colour_attr_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam int unsigned CW = 4;
  localparam int unsigned LW = 3;
  localparam logic [AW-1:0] CTRL_PORT = 16'h7FEF;
  localparam logic [AW-1:0] ATTR_BASE = 16'hC000;
  localparam logic [AW-1:0] DFILE_MIN = 16'h2000;
  localparam logic [CW-1:0] WHITE_HI  = 4'b1111;
  localparam logic [CW-1:0] BLACK     = 4'b0000;

  typedef struct packed {
    logic          en;
    logic          mode;
    logic [CW-1:0] border;
  } ctrl_t;

  localparam ctrl_t CTRL_FALLBACK = '{en: 1'b0, mode: 1'b0, border: WHITE_HI};

  // Table entry: base + {code[7], code[5:0]} * 8 + line
  function automatic logic [AW-1:0] f_lut_addr(input logic [7:0] code,
                                               input logic [LW-1:0] line);
    logic [6:0] idx;
    idx = {code[7], code[5:0]};
    return ATTR_BASE + {6'b0, idx, line};
  endfunction

  function automatic logic [AW-1:0] f_copy_addr(input logic [AW-1:0] dfa);
    return dfa | ATTR_BASE;
  endfunction

  function automatic logic [CW-1:0] f_pick(input logic [DW-1:0] attr,
                                           input logic pix, input logic en);
    if (!en) return pix ? BLACK : WHITE_HI;
    return pix ? attr[CW-1:0] : attr[DW-1:CW];
  endfunction
endpackage

// File: rtl/cattr_reg.sv
module cattr_reg
  import colour_attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic          sw_on,
  output ctrl_t         ctrl_eff,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data
);
  logic  wr_hit;
  logic  port_sel;
  ctrl_t ctrl_q;
  ctrl_t ctrl_wr;
  logic  unused_wbits;

  assign port_sel     = (io_addr == CTRL_PORT);
  assign wr_hit       = io_wr && port_sel;
  assign unused_wbits = ^io_wdata[DW-1:6];
  assign ctrl_wr      = '{en: io_wdata[5], mode: io_wdata[4], border: io_wdata[CW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= CTRL_FALLBACK;
    else if (!sw_on) ctrl_q <= CTRL_FALLBACK;
    else if (wr_hit) ctrl_q <= ctrl_wr;
  end

  assign ctrl_eff = sw_on ? ctrl_q : CTRL_FALLBACK;
  assign rd_hit   = io_rd && port_sel;
  assign rd_data  = rd_hit ? {1'b1, ~sw_on, 6'b111111} : 8'hFF;

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && sw_on) |=> (ctrl_q == $past(ctrl_wr)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && sw_on && $past(sw_on)) |=> $stable(ctrl_q));
  a_r3_force: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_on |=> (ctrl_q == CTRL_FALLBACK));
  a_r4_status: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_data[6] != sw_on));
endmodule

// File: rtl/cattr_addr.sv
module cattr_addr
  import colour_attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [7:0]    char_code,
  input  logic [LW-1:0] char_line,
  input  logic [AW-1:0] dfile_addr,
  output logic [AW-1:0] attr_addr,
  output logic          attr_ok
);
  logic [AW-1:0] lut_a;
  logic [AW-1:0] copy_a;
  logic          dfile_low;

  assign lut_a     = f_lut_addr(char_code, char_line);
  assign copy_a    = f_copy_addr(dfile_addr);
  assign dfile_low = (dfile_addr < DFILE_MIN);
  assign attr_addr = ctrl.mode ? copy_a : lut_a;
  assign attr_ok   = ctrl.en && (!ctrl.mode || !dfile_low);

  a_r5_lut_window: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.mode |-> (attr_addr[AW-1:10] == 6'b110000));
  a_r6_copy_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.mode |-> (attr_addr[13:0] == dfile_addr[13:0] && attr_addr[15:14] == 2'b11));
  a_r7_low_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode && dfile_addr[15:13] == 3'b000) |-> !attr_ok);
endmodule

// File: rtl/cattr_pix.sv
module cattr_pix
  import colour_attr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_en,
  input  logic [DW-1:0] attr_data,
  input  logic          pixel_bit,
  output logic [CW-1:0] pix_colour
);
  assign pix_colour = f_pick(attr_data, pixel_bit, col_en);

  a_r8_pen: assert property (@(posedge clk) disable iff (!rst_n)
    (col_en && pixel_bit) |-> (pix_colour == attr_data[3:0]));
  a_r9_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !col_en |-> ($countones(pix_colour) == (pixel_bit ? 0 : 4)));
endmodule

// File: rtl/colour_attr_ctrl.sv
module colour_attr_ctrl
  import colour_attr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic        cfg_colour_en,
  input  logic [7:0]  char_code,
  input  logic [2:0]  char_line,
  input  logic [15:0] dfile_addr,
  input  logic        pixel_bit,
  input  logic [7:0]  attr_data,
  output logic [15:0] attr_addr,
  output logic        attr_ok,
  output logic [3:0]  pix_colour,
  output logic [3:0]  border_colour,
  output logic        io_rd_hit,
  output logic [7:0]  io_rdata
);
  ctrl_t ctrl_eff;

  cattr_reg u_reg (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .sw_on(cfg_colour_en),
    .ctrl_eff(ctrl_eff), .rd_hit(io_rd_hit), .rd_data(io_rdata)
  );

  cattr_addr u_addr (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_eff), .char_code(char_code),
    .char_line(char_line), .dfile_addr(dfile_addr),
    .attr_addr(attr_addr), .attr_ok(attr_ok)
  );

  cattr_pix u_pix (
    .clk(clk), .rst_n(rst_n), .col_en(ctrl_eff.en), .attr_data(attr_data),
    .pixel_bit(pixel_bit), .pix_colour(pix_colour)
  );

  assign border_colour = ctrl_eff.border;

  a_r3_border_white: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_colour_en |-> (border_colour == 4'hF && !attr_ok));
  a_r10_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (border_colour == 4'hF));
endmodule

// File: tb/sim_colour_attr_ctrl.sv
module sim_colour_attr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0, cfg_colour_en = 1'b1;
  logic [7:0]  char_code = 8'h0;
  logic [2:0]  char_line = 3'h0;
  logic [15:0] dfile_addr = 16'h0;
  logic        pixel_bit = 1'b0;
  logic [7:0]  attr_data = 8'h0;
  logic [15:0] attr_addr;
  logic        attr_ok, io_rd_hit;
  logic [3:0]  pix_colour, border_colour;
  logic [7:0]  io_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  colour_attr_ctrl u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 border", 16'(border_colour), 16'hF);
    char_code = 8'h85; char_line = 3'd2; dfile_addr = 16'h4000;
    #1 chk("R10 mode0 addr", attr_addr, 16'hC000 + 16'(7'h45) * 8 + 2);
    chk("R10 colour off", 16'(attr_ok), 16'h0);
  endtask

  task automatic t_write();
    wr_port(16'h7FEF, 8'h25);
    chk("R1 border", 16'(border_colour), 16'h5);
    chk("R1 enable", 16'(attr_ok), 16'h1);
    wr_port(16'h7FEF, 8'h3A);
    chk("R1 border2", 16'(border_colour), 16'hA);
    dfile_addr = 16'h4321;
    #1 chk("R1 mode1", attr_addr, 16'hC321);
  endtask

  task automatic t_other();
    wr_port(16'h7FEE, 8'h07);
    chk("R2 border kept", 16'(border_colour), 16'hA);
    wr_port(16'hFEEF, 8'h00);
    chk("R2 mode kept", attr_addr, 16'hC321);
  endtask

  task automatic t_switch();
    @(negedge clk); cfg_colour_en = 1'b0; #1;
    chk("R3 border white", 16'(border_colour), 16'hF);
    chk("R3 colour off", 16'(attr_ok), 16'h0);
    chk("R3 mode0", attr_addr, 16'hC000 + 16'(7'h45) * 8 + 2);
    wr_port(16'h7FEF, 8'h32);
    chk("R3 write ignored", 16'(border_colour), 16'hF);
    @(negedge clk); cfg_colour_en = 1'b1;
    @(negedge clk);
    chk("R3 fallback kept", 16'(border_colour), 16'hF);
    chk("R3 fallback off", 16'(attr_ok), 16'h0);
  endtask

  task automatic t_status();
    @(negedge clk); io_addr = 16'h7FEF; io_rd = 1'b1; #1;
    chk("R4 hit", 16'(io_rd_hit), 16'h1);
    chk("R4 data on", 16'(io_rdata), 16'hBF);
    cfg_colour_en = 1'b0; #1;
    chk("R4 data off", 16'(io_rdata), 16'hFF);
    io_addr = 16'h7FEE; cfg_colour_en = 1'b1; #1;
    chk("R4 miss", 16'(io_rd_hit), 16'h0);
    chk("R4 miss data", 16'(io_rdata), 16'hFF);
    io_rd = 1'b0;
  endtask

  task automatic t_mode0();
    wr_port(16'h7FEF, 8'h21);
    for (int k = 0; k < 4; k++) begin
      char_code = 8'(k * 8'h47 + 8'h13); char_line = 3'(k * 3 + 1); #1;
      chk("R5 lut addr", attr_addr,
          16'hC000 + 16'({char_code[7], char_code[5:0]}) * 16'd8 + 16'(char_line));
    end
    char_code = 8'hBF; char_line = 3'd7; #1;
    chk("R5 top entry", attr_addr, 16'hC3FF);
    char_code = 8'hFF; #1;
    chk("R5 bit6 ignored", attr_addr, 16'hC3FF);
    dfile_addr = 16'h0100; #1;
    chk("R7 mode0 ok", 16'(attr_ok), 16'h1);
  endtask

  task automatic t_mode1();
    wr_port(16'h7FEF, 8'h31);
    dfile_addr = 16'h2000; #1;
    chk("R6 8K", attr_addr, 16'hE000);
    chk("R7 at 8K ok", 16'(attr_ok), 16'h1);
    dfile_addr = 16'h8ABC; #1;
    chk("R6 32K", attr_addr, 16'hCABC);
    dfile_addr = 16'h1FFF; #1;
    chk("R7 below 8K", 16'(attr_ok), 16'h0);
  endtask

  task automatic t_pixel();
    attr_data = 8'h9C; pixel_bit = 1'b1; #1;
    chk("R8 pen", 16'(pix_colour), 16'hC);
    pixel_bit = 1'b0; #1;
    chk("R8 paper", 16'(pix_colour), 16'h9);
    wr_port(16'h7FEF, 8'h01);
    attr_data = 8'h5A; pixel_bit = 1'b1; #1;
    chk("R9 mono set", 16'(pix_colour), 16'h0);
    pixel_bit = 1'b0; #1;
    chk("R9 mono clear", 16'(pix_colour), 16'hF);
    chk("R9 border", 16'(border_colour), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_other();
    t_switch();
    t_status();
    t_mode0();
    t_mode1();
    t_pixel();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule